// File: doc/BRIEF.md
# Four-Wheel-Steering Mode Selector

This block picks which steering arrangement a four-wheel-steered model runs in. A front end measures the mode-switch channel once per check period and hands over a 3-bit status code together with a one-cycle strobe. The selector reads that code and an 8-bit configuration byte, and produces a 3-bit mode. The codes are 1 for all-wheel, 2 for front only, 3 for rear only and 4 for crab. A separate pulse generator turns the mode into servo commands.

There are two ways to choose a mode. In direct mode, each of the three switch positions maps straight to a mode. The high position always means all-wheel. The neutral and low positions are looked up in one of four tables, chosen by a 2-bit select. In cyclic mode, a gesture on the switch moves to the next mode in a ring of enabled modes. The gesture is either a high-to-low move or two transitions in quick succession. A lockout pin forces front-only steering at the output whatever the switch is doing. Bit 0 of the configuration byte is passed straight through as a flag that reverses the rear channel.

Internally, a two-state gesture machine has the states G_IDLE and G_ARMED. G_IDLE goes to G_ARMED on a first transition, but only in double-transition mode. G_ARMED goes back to G_IDLE in any of three cases: the second transition arrives (an advance), the gap window runs out, or the trigger mode changes. The mode register starts at all-wheel. It moves only on a strobe, and there are two paths: a table lookup in direct mode, or a ring step in cyclic mode.

Top module: `steer_mode_sel`

## Requirements
- R1: After reset the output mode is 1 (all-wheel) with the lockout released, and the gesture machine is in G_IDLE.
- R2: In direct mode (cfg bit 1 = 0), a valid sample that is not in the deadband and has the above-centre bit set gives mode 1. The status code is: bit 0 valid, bit 1 above centre, bit 2 in deadband.
- R3: In direct mode, the position is neutral when the sample is valid and bit 2 is set. It is low when the sample is valid and bits 2 and 1 are both clear. The table select is cfg bits 3:2, and it maps neutral and low as follows: 00 gives 2 and 3, 01 gives 3 and 2, 10 gives 4 and 2, 11 gives 2 and 4.
- R4: An invalid sample (bit 0 = 0) leaves the mode unchanged. In cyclic mode, no transition is ever formed with an invalid sample as either its current or its previous sample.
- R5: The mode register changes only in a cycle where the strobe is high.
- R6: In cyclic mode (cfg bit 1 = 1), each advance goes to the next mode in this ring: 1, 2, then 3 if cfg bit 4 is set, then 4 if cfg bit 5 is set, then back to 1.
- R7: When cfg bit 6 = 0, an advance happens when a valid above-centre sample is followed by a valid sample with the above-centre bit clear. A low-to-high move does not advance.
- R8: When cfg bit 6 = 1, an advance needs two changes of the above-centre bit. The second change must come no more than MAX_GAP strobes (default 5) after the first. A later second change is not counted as a second change; it becomes the first change of a new pair.
- R9: While the lockout input is high, the output mode is 2. The internal mode keeps following the switch, and it shows again once the lockout is released.
- R10: The rear-reverse output always equals cfg bit 0.
- R11: The mode is always one of the codes 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_stb_i | input | 1 | One-cycle strobe: a new status sample is present |
| stat_code_i | input | 3 | Status: bit0 valid, bit1 above centre, bit2 in deadband |
| cfg_i | input | 8 | Configuration byte |
| lockout_i | input | 1 | Forces front-only steering when high |
| mode_o | output | 3 | Active steering mode, 1 to 4 |
| rear_rev_o | output | 1 | Rear-channel reverse flag |

## Verification
Some properties are checked by assertions on every cycle:
- The mode stays legal, and it moves only on a strobe.
- An invalid sample never changes the mode.
- A high direct sample always yields all-wheel.
- An armed gesture window never overstays its gap limit.
- A high-to-low advance always comes from a real high-then-low pair.
- The lockout forces front-only at the output.

Other properties need the bench's scenarios:
- The exact table contents for each select value.
- The ring order, including the wrap and the skipping of disabled modes.
- Whether a second transition at exactly the gap limit still counts, while one a strobe later does not.

// File: rtl/steer_mode_pkg.sv
package steer_mode_pkg;

    typedef enum logic [2:0] {
        MODE_ALL   = 3'd1,
        MODE_FRONT = 3'd2,
        MODE_REAR  = 3'd3,
        MODE_CRAB  = 3'd4
    } steer_mode_e;

    typedef enum logic [1:0] {
        POS_NONE = 2'd0,
        POS_HIGH = 2'd1,
        POS_MID  = 2'd2,
        POS_LOW  = 2'd3
    } sw_pos_e;

    typedef enum logic {
        G_IDLE  = 1'b0,
        G_ARMED = 1'b1
    } gest_state_e;

    localparam int CFG_REV   = 0;
    localparam int CFG_CYC   = 1;
    localparam int CFG_TSEL0 = 2;
    localparam int CFG_TSEL1 = 3;
    localparam int CFG_EN_RR = 4;
    localparam int CFG_EN_CB = 5;
    localparam int CFG_DBL   = 6;

    localparam int ST_VALID = 0;
    localparam int ST_ABOVE = 1;
    localparam int ST_DEAD  = 2;

    function automatic steer_mode_e ring_next(steer_mode_e cur, logic en_rear, logic en_crab);
        steer_mode_e nxt;
        unique case (cur)
            MODE_ALL:   nxt = MODE_FRONT;
            MODE_FRONT: nxt = en_rear ? MODE_REAR : (en_crab ? MODE_CRAB : MODE_ALL);
            MODE_REAR:  nxt = en_crab ? MODE_CRAB : MODE_ALL;
            default:    nxt = MODE_ALL;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sw_pos_decode.sv
module sw_pos_decode
    import steer_mode_pkg::*;
(
    input  logic [2:0] code_i,
    output sw_pos_e    pos_o
);
    always_comb begin
        if (!code_i[ST_VALID])
            pos_o = POS_NONE;
        else if (code_i[ST_DEAD])
            pos_o = POS_MID;
        else if (code_i[ST_ABOVE])
            pos_o = POS_HIGH;
        else
            pos_o = POS_LOW;
    end
endmodule

// File: rtl/direct_map.sv
module direct_map
    import steer_mode_pkg::*;
(
    input  sw_pos_e     pos_i,
    input  logic [1:0]  tsel_i,
    output steer_mode_e mode_o
);
    steer_mode_e mid_m;
    steer_mode_e low_m;

    always_comb begin
        unique case (tsel_i)
            2'b00: begin mid_m = MODE_FRONT; low_m = MODE_REAR;  end
            2'b01: begin mid_m = MODE_REAR;  low_m = MODE_FRONT; end
            2'b10: begin mid_m = MODE_CRAB;  low_m = MODE_FRONT; end
            default: begin mid_m = MODE_FRONT; low_m = MODE_CRAB; end
        endcase
    end

    always_comb begin
        unique case (pos_i)
            POS_MID: mode_o = mid_m;
            POS_LOW: mode_o = low_m;
            default: mode_o = MODE_ALL;
        endcase
    end
endmodule

// File: rtl/gesture_fsm.sv
module gesture_fsm
    import steer_mode_pkg::*;
#(
    parameter int MAX_GAP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic valid_i,
    input  logic above_i,
    input  logic dbl_i,
    output logic advance_o
);
    localparam int GW = $clog2(MAX_GAP + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(MAX_GAP - 1);

    gest_state_e   state_q, state_d;
    logic [GW-1:0] gap_q, gap_d;
    logic          prev_valid_q, prev_above_q;
    logic          flip, fall;

    always_comb begin
        flip = stb_i && valid_i && prev_valid_q && (above_i != prev_above_q);
        fall = stb_i && valid_i && prev_valid_q && prev_above_q && !above_i;
    end

    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            G_IDLE: begin
                if (dbl_i && flip) begin
                    state_d = G_ARMED;
                    gap_d   = '0;
                end
            end
            G_ARMED: begin
                if (!dbl_i) begin
                    state_d = G_IDLE;
                end else if (stb_i) begin
                    if (flip || gap_q == GAP_LAST)
                        state_d = G_IDLE;
                    else
                        gap_d = gap_q + 1'b1;
                end
            end
            default: state_d = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= G_IDLE;
            gap_q        <= '0;
            prev_valid_q <= 1'b0;
            prev_above_q <= 1'b0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
            if (stb_i) begin
                prev_valid_q <= valid_i;
                prev_above_q <= above_i;
            end
        end
    end

    always_comb begin
        if (dbl_i)
            advance_o = (state_q == G_ARMED) && flip;
        else
            advance_o = fall;
    end

    a_r8_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == G_ARMED |-> gap_q < GW'(MAX_GAP));
    a_r7_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_o && !dbl_i) |-> (prev_above_q && !above_i && valid_i));
    a_r4_no_invalid_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !valid_i) |-> !advance_o);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> state_q == G_IDLE);
endmodule

// File: rtl/steer_mode_sel.sv
module steer_mode_sel
    import steer_mode_pkg::*;
#(
    parameter int MAX_GAP = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_stb_i,
    input  logic [2:0] stat_code_i,
    input  logic [7:0] cfg_i,
    input  logic       lockout_i,
    output logic [2:0] mode_o,
    output logic       rear_rev_o
);
    sw_pos_e     pos;
    steer_mode_e tab_mode;
    steer_mode_e mode_q;
    logic        advance;

    sw_pos_decode u_pos (
        .code_i (stat_code_i),
        .pos_o  (pos)
    );

    direct_map u_map (
        .pos_i  (pos),
        .tsel_i ({cfg_i[CFG_TSEL1], cfg_i[CFG_TSEL0]}),
        .mode_o (tab_mode)
    );

    gesture_fsm #(.MAX_GAP(MAX_GAP)) u_gest (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (stat_stb_i),
        .valid_i   (stat_code_i[ST_VALID]),
        .above_i   (stat_code_i[ST_ABOVE]),
        .dbl_i     (cfg_i[CFG_DBL]),
        .advance_o (advance)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_ALL;
        end else if (stat_stb_i && stat_code_i[ST_VALID]) begin
            if (!cfg_i[CFG_CYC])
                mode_q <= tab_mode;
            else if (advance)
                mode_q <= ring_next(mode_q, cfg_i[CFG_EN_RR], cfg_i[CFG_EN_CB]);
        end
    end

    always_comb begin
        mode_o     = lockout_i ? MODE_FRONT : mode_q;
        rear_rev_o = cfg_i[CFG_REV];
    end

    a_r11_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q >= MODE_ALL) && (mode_q <= MODE_CRAB));
    a_r5_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_stb_i |=> $stable(mode_q));
    a_r4_invalid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_stb_i && !stat_code_i[ST_VALID]) |=> $stable(mode_q));
    a_r2_high_is_all: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_stb_i && !cfg_i[CFG_CYC] && pos == POS_HIGH) |=> mode_q == MODE_ALL);
    a_r9_lockout_front: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_i |-> mode_o == 3'd2);
endmodule

// File: tb/steer_mode_sel_tb.sv
module steer_mode_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0;
    logic [2:0] code = 3'b000;
    logic [7:0] cfg = 8'h00;
    logic       lock = 1'b0;
    logic [2:0] mode;
    logic       rrev;

    int total = 0;
    int bad   = 0;

    localparam logic [2:0] HI  = 3'b011;
    localparam logic [2:0] LO  = 3'b001;
    localparam logic [2:0] NEU = 3'b101;
    localparam logic [2:0] INV = 3'b000;

    always #2.5 clk = ~clk;

    steer_mode_sel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_stb_i  (stb),
        .stat_code_i (code),
        .cfg_i       (cfg),
        .lockout_i   (lock),
        .mode_o      (mode),
        .rear_rev_o  (rrev)
    );

    // {cfg, code, expected mode} in direct mode (R2, R3, R4)
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {8'h00, HI,  3'd1}, {8'h00, NEU, 3'd2}, {8'h00, LO,  3'd3},
        {8'h00, INV, 3'd3}, {8'h04, NEU, 3'd3}, {8'h04, LO,  3'd2},
        {8'h08, NEU, 3'd4}, {8'h08, LO,  3'd2}, {8'h0C, NEU, 3'd2},
        {8'h0C, LO,  3'd4}, {8'h0C, HI,  3'd1}, {8'h0C, INV, 3'd1},
        {8'h01, LO,  3'd3}
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] c);
        @(negedge clk);
        code = c;
        stb  = 1'b1;
        @(negedge clk);
        stb  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #300000;
        bad++;
        total++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 reset mode", mode, 3'd1);

        for (int i = 0; i < NV; i++) begin
            cfg = VEC[i][13:6];
            send(VEC[i][5:3]);
            check("R3 direct table vector", mode, VEC[i][2:0]);
        end
        check("R10 rear reverse set", {2'b0, rrev}, 3'd1);
        cfg = 8'h00;
        #1;
        check("R10 rear reverse clear", {2'b0, rrev}, 3'd0);

        // R5: no strobe, no change
        @(negedge clk);
        code = HI;
        repeat (3) @(negedge clk);
        check("R5 no strobe no change", mode, 3'd3);
        send(HI);
        check("R2 high gives all-wheel", mode, 3'd1);

        // R9 lockout
        lock = 1'b1;
        #1;
        check("R9 lockout forces front", mode, 3'd2);
        send(LO);
        check("R9 lockout during change", mode, 3'd2);
        lock = 1'b0;
        #1;
        check("R9 release shows internal", mode, 3'd3);

        // cyclic, high-to-low, rear and crab enabled
        do_reset();
        cfg = 8'h32;
        send(HI);
        check("R4 no previous valid sample", mode, 3'd1);
        send(LO);
        check("R7 fall advances", mode, 3'd2);
        send(HI);
        check("R7 rise does not advance", mode, 3'd2);
        send(LO);
        check("R6 ring to rear", mode, 3'd3);
        send(HI); send(LO);
        check("R6 ring to crab", mode, 3'd4);
        send(HI); send(LO);
        check("R6 ring wraps", mode, 3'd1);
        send(HI); send(INV); send(LO);
        check("R4 invalid breaks transition", mode, 3'd1);

        cfg = 8'h02;
        send(HI); send(LO);
        check("R6 minimal ring step", mode, 3'd2);
        send(HI); send(LO);
        check("R6 minimal ring wraps", mode, 3'd1);
        cfg = 8'h12;
        send(HI); send(LO); send(HI); send(LO);
        check("R6 rear enabled", mode, 3'd3);
        send(HI); send(LO);
        check("R6 rear wraps past crab", mode, 3'd1);
        cfg = 8'h22;
        send(HI); send(LO); send(HI); send(LO);
        check("R6 crab skips rear", mode, 3'd4);
        send(HI); send(LO);
        check("R6 crab wraps", mode, 3'd1);

        // double transition mode; previous sample is LO
        cfg = 8'h42;
        send(HI);
        check("R8 first flip holds", mode, 3'd1);
        send(LO);
        check("R8 quick double advances", mode, 3'd2);
        send(HI);
        repeat (4) send(HI);
        send(LO);
        check("R8 second flip at limit", mode, 3'd1);
        send(HI);
        repeat (5) send(HI);
        send(LO);
        check("R8 late second flip ignored", mode, 3'd1);
        send(HI);
        check("R8 late flip re-arms", mode, 3'd2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule